// File: doc/BRIEF.md
# Packed Pixel Input Queue with Unpacker

This block sits between a memory fetch engine and a display pixel pipeline. The fetch engine delivers 32-bit words. Each pair of words forms one 64-bit entry in an eight-deep queue. An unpacker then reads the oldest entry and hands it to the pixel pipeline as a stream of pixel codes. Each code is 1, 2, 4, 8 or 16 bits wide, zero-extended to 16 bits.

The block asks the fetch engine for more data in fixed chunks. One request is answered by a burst of eight words, which is four entries. At most one request is active at a time. When the pixel side wants a pixel and none is held, the block latches an underrun flag. Software clears the flag by writing one to it, and the flag drives an interrupt that can be masked. A dual-panel display uses one instance for each half of the screen, each with its own request line and underrun flag.

Both data paths use valid/ready handshakes. A word transfers on a clock edge where `wr_valid` and `wr_ready` are both high. A pixel transfers on an edge where `pix_valid` and `pix_ready` are both high. While `pix_valid` is high and `pix_ready` is low, the offered pixel is held. `wr_ready` is low only while all eight entries are full. `bpp_sel` must be held steady while `enable` is high.

Top module: `pix_feed_queue`

## Requirements
- R1: After reset, `dma_req`, `pix_valid`, `urun_sts` and `irq` are 0 and `wr_ready` is 1.
- R2: When `enable` is high, no burst is outstanding and at least four entries are free, `dma_req` rises one cycle later. It falls in the cycle after the first word of the burst is accepted, and stays low until the eighth word of that burst has been accepted.
- R3: Within a word pair, the first accepted word supplies entry bits 31:0 and the second supplies bits 63:32. Entries leave in arrival order. With eight full entries, `wr_ready` is 0.
- R4: After a burst completes, a new request is made only if at least four entries are free. With the queue full and the pixel side stalled, `dma_req` stays 0.
- R5: `bpp_sel` chooses the pixel width b: 0 gives 1 bit, 1 gives 2 bits, 2 gives 4 bits, 3 gives 8 bits, and 4 gives 16 bits. Values 5 to 7 also give 16 bits. Pixel k of an entry is entry bits [k*b+b-1 : k*b], zero-extended to 16 bits, and pixels are sent from k = 0 upward.
- R6: `pix_valid` is high exactly while an entry is queued. `pix_data` holds steady while the pixel is offered and not taken. The entry is removed after its 64/b-th pixel is taken.
- R7: A clock edge with `enable` high, `pix_ready` high and `pix_valid` low sets `urun_sts`, and the flag stays set without a clear.
- R8: A cycle with `urun_clr` high clears `urun_sts` at the next edge, unless a new underrun occurs in that same cycle, in which case the flag stays set.
- R9: `irq` is 1 exactly when `urun_sts` is 1 and `urun_mask` is 0.
- R10: With `enable` low, the block discards all queued entries, any half-assembled pair and the position within the current entry, and withdraws `dma_req`. `urun_sts` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; low flushes the queue |
| bpp_sel | input | 3 | Pixel width code |
| dma_req | output | 1 | Request for one eight-word burst |
| wr_valid | input | 1 | Word offered by fetch engine |
| wr_data | input | 32 | Fetched word |
| wr_ready | output | 1 | Queue can take a word |
| pix_valid | output | 1 | Pixel code available |
| pix_ready | input | 1 | Pixel side takes / demands a pixel |
| pix_data | output | 16 | Pixel code, zero-extended |
| urun_clr | input | 1 | Write-one-to-clear pulse for underrun flag |
| urun_mask | input | 1 | Interrupt mask |
| urun_sts | output | 1 | Sticky underrun flag |
| irq | output | 1 | Underrun interrupt |

## Verification
A wrong entry count shows up at the ports in one of two ways. The request line can rise while a burst is still unfinished, or it can fail to rise after the fourth free slot opens, and either appears within one cycle. A wrong pixel index or word order shows up as a wrong `pix_data` value on the next handshake. A missed pop shows up later, as repeated pixels that the reference queue catches within one entry. A flush that leaves stale entries or a stale index appears as soon as the first pixel after re-enable is compared.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  typedef enum logic [1:0] {
    RQ_IDLE,
    RQ_WAIT,
    RQ_BURST
  } req_state_e;

  // Pixel width exponent; codes above 4 alias to 16-bit pixels.
  function automatic logic [2:0] width_log2(input logic [2:0] sel);
    return (sel > 3'd4) ? 3'd4 : sel;
  endfunction
endpackage

// File: rtl/pxf_pair_queue.sv
module pxf_pair_queue #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  localparam int ENTRY_W = 2 * WORD_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_valid,
  input  logic [WORD_W-1:0]  wr_data,
  output logic               wr_ready,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic               head_valid,
  output logic [CNT_W-1:0]   count
);
  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [WORD_W-1:0]  low_q;
  logic               half_q;
  logic               wr_fire, push;
  logic [ENTRY_W-1:0] new_entry;

  assign wr_ready   = (count < CNT_W'(DEPTH));
  assign wr_fire    = wr_valid && wr_ready;
  assign push       = wr_fire && half_q;
  assign new_entry  = {wr_data, low_q};
  assign head       = slots[0];
  assign head_valid = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      half_q <= 1'b0;
      low_q  <= '0;
    end else if (flush) begin
      count  <= '0;
      half_q <= 1'b0;
    end else begin
      if (wr_fire) begin
        if (half_q) half_q <= 1'b0;
        else begin
          low_q  <= wr_data;
          half_q <= 1'b1;
        end
      end
      count <= count + CNT_W'(push) - CNT_W'(pop && head_valid);
    end
  end

  // Shift-down storage: slot 0 is always the oldest entry.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop && head_valid) begin
        if (push && (count == CNT_W'(i + 1))) slots[i] <= new_entry;
        else if (i < DEPTH - 1) slots[i] <= slots[i + 1];
      end else if (push && (count == CNT_W'(i))) begin
        slots[i] <= new_entry;
      end
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> count == $past(count) + 1'b1);
  assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head_valid && !push && !flush) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/pxf_unpacker.sv
module pxf_unpacker #(
  parameter int ENTRY_W = 64,
  parameter int PIX_W   = 16,
  localparam int IDX_W  = $clog2(ENTRY_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [2:0]         bpp_sel,
  input  logic [ENTRY_W-1:0] head,
  input  logic               head_valid,
  output logic               pop,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [PIX_W-1:0]   pix_data
);
  import pxf_pkg::*;

  logic [IDX_W-1:0]   idx_q;
  logic [2:0]         lg;
  logic [IDX_W-1:0]   last_idx;
  logic [IDX_W-1:0]   shamt;
  logic [ENTRY_W-1:0] shifted;
  logic [31:0]        wmask;
  logic               fire;

  assign lg       = width_log2(bpp_sel);
  assign last_idx = IDX_W'((ENTRY_W >> lg) - 1);
  assign shamt    = IDX_W'(idx_q << lg);
  assign shifted  = head >> shamt;
  assign wmask    = (32'd1 << (32'd1 << lg)) - 32'd1;
  assign pix_data = shifted[PIX_W-1:0] & wmask[PIX_W-1:0];

  assign pix_valid = head_valid;
  assign fire      = pix_valid && pix_ready;
  assign pop       = fire && (idx_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) idx_q <= '0;
    else if (fire)       idx_q <= pop ? '0 : idx_q + 1'b1;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last_idx);
endmodule

// File: rtl/pxf_req_ctrl.sv
module pxf_req_ctrl #(
  parameter int DEPTH         = 8,
  parameter int BURST_ENTRIES = 4,
  localparam int CNT_W        = $clog2(DEPTH + 1),
  localparam int BURST_WORDS  = 2 * BURST_ENTRIES,
  localparam int BW_W         = $clog2(BURST_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  input  logic             wr_fire,
  output logic             dma_req
);
  import pxf_pkg::*;

  req_state_e       st_q;
  logic [BW_W-1:0]  wcnt_q;
  logic [CNT_W-1:0] free_slots;

  assign free_slots = CNT_W'(DEPTH) - count;
  assign dma_req    = (st_q == RQ_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RQ_IDLE;
      wcnt_q <= '0;
    end else if (!enable) begin
      st_q   <= RQ_IDLE;
      wcnt_q <= '0;
    end else begin
      unique case (st_q)
        RQ_IDLE: if (free_slots >= CNT_W'(BURST_ENTRIES)) st_q <= RQ_WAIT;
        RQ_WAIT: if (wr_fire) begin
          st_q   <= RQ_BURST;
          wcnt_q <= BW_W'(1);
        end
        RQ_BURST: if (wr_fire) begin
          if (wcnt_q == BW_W'(BURST_WORDS - 1)) begin
            st_q   <= RQ_IDLE;
            wcnt_q <= '0;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: st_q <= RQ_IDLE;
      endcase
    end
  end

  assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && wr_fire) |=> !dma_req);
  assert_req_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> ($past(count) <= CNT_W'(DEPTH - BURST_ENTRIES)));
  assert_req_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !dma_req);
endmodule

// File: rtl/pxf_urun_flag.sv
module pxf_urun_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pix_valid,
  input  logic pix_ready,
  input  logic clr,
  input  logic mask,
  output logic sts,
  output logic irq
);
  logic hit;

  assign hit = enable && pix_ready && !pix_valid;
  assign irq = sts && !mask;

  always_ff @(posedge clk) begin
    if (!rst_n)   sts <= 1'b0;
    else if (hit) sts <= 1'b1;
    else if (clr) sts <= 1'b0;
  end

  assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> sts);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr) |=> sts);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !sts);
endmodule

// File: rtl/pix_feed_queue.sv
module pix_feed_queue #(
  parameter int WORD_W        = 32,
  parameter int DEPTH         = 8,
  parameter int BURST_ENTRIES = 4,
  parameter int PIX_W         = 16,
  localparam int ENTRY_W      = 2 * WORD_W,
  localparam int CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [2:0]        bpp_sel,
  output logic              dma_req,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [PIX_W-1:0]  pix_data,
  input  logic              urun_clr,
  input  logic              urun_mask,
  output logic              urun_sts,
  output logic              irq
);
  logic [ENTRY_W-1:0] head;
  logic               head_valid;
  logic               pop;
  logic [CNT_W-1:0]   count;

  pxf_pair_queue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) queue_i (
    .clk(clk), .rst_n(rst_n), .flush(!enable),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .pop(pop), .head(head), .head_valid(head_valid), .count(count)
  );

  pxf_unpacker #(.ENTRY_W(ENTRY_W), .PIX_W(PIX_W)) unpack_i (
    .clk(clk), .rst_n(rst_n), .flush(!enable), .bpp_sel(bpp_sel),
    .head(head), .head_valid(head_valid), .pop(pop),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data)
  );

  pxf_req_ctrl #(.DEPTH(DEPTH), .BURST_ENTRIES(BURST_ENTRIES)) req_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .count(count),
    .wr_fire(wr_valid && wr_ready), .dma_req(dma_req)
  );

  pxf_urun_flag flag_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .clr(urun_clr), .mask(urun_mask), .sts(urun_sts), .irq(irq)
  );

  assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_sts && !urun_mask) |-> irq);
endmodule

// File: tb/pix_feed_queue_tb_top.sv
`timescale 1ns/1ps
module pix_feed_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  bpp_sel = 3'd0;
  logic        dma_req, wr_ready, pix_valid, urun_sts, irq;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pix_ready = 1'b0;
  logic [15:0] pix_data;
  logic        urun_clr = 1'b0;
  logic        urun_mask = 1'b0;

  always #4 clk = ~clk;

  pix_feed_queue dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bpp_sel(bpp_sel),
    .dma_req(dma_req), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .urun_clr(urun_clr), .urun_mask(urun_mask), .urun_sts(urun_sts), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_q[$];
  logic [31:0] lo_w;
  bit          have_lo;
  int          pidx;
  int          words_left;
  bit          burst_on;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_pix(input logic [63:0] e, input int k, input logic [2:0] sel);
    int lg = (sel > 3'd4) ? 4 : int'(sel);
    int b = 1 << lg;
    logic [63:0] v = (e >> (k * b)) & ((64'd1 << b) - 64'd1);
    return v[15:0];
  endfunction

  function automatic int per_entry(input logic [2:0] sel);
    return 64 >> ((sel > 3'd4) ? 4 : int'(sel));
  endfunction

  task automatic model_clear();
    exp_q.delete(); have_lo = 0; pidx = 0; words_left = 0; burst_on = 0;
  endtask

  // Disable (flush), pick width, re-enable.
  task automatic restart(input logic [2:0] sel);
    @(negedge clk);
    enable = 0; wr_valid = 0; pix_ready = 0;
    @(negedge clk); #1;
    chk(pix_valid == 0, "R10 flush valid", pix_valid, 0);
    chk(dma_req == 0, "R10 req withdrawn", dma_req, 0);
    model_clear();
    bpp_sel = sel; enable = 1;
  endtask

  task automatic run_random(input int cycles, input int rdy_pct, input int val_pct);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      wr_valid  = (words_left > 0) && (($urandom % 100) < val_pct);
      wr_data   = $urandom;
      pix_ready = (($urandom % 100) < rdy_pct);
      #1;
      if (burst_on) chk(dma_req == 0, "R2 one request outstanding", dma_req, 0);
      chk(pix_valid == (exp_q.size() != 0), "R6 valid tracks queue", pix_valid, exp_q.size() != 0);
      chk(wr_ready == (exp_q.size() < 8), "R3 ready vs fill", wr_ready, exp_q.size() < 8);
      if (pix_valid && pix_ready && exp_q.size() != 0) begin
        logic [15:0] e = exp_pix(exp_q[0], pidx, bpp_sel);
        chk(pix_data == e, "R5 pixel value", pix_data, e);
        pidx++;
        if (pidx == per_entry(bpp_sel)) begin pidx = 0; void'(exp_q.pop_front()); end
      end
      if (wr_valid && wr_ready) begin
        if (have_lo) begin exp_q.push_back({wr_data, lo_w}); have_lo = 0; end
        else begin lo_w = wr_data; have_lo = 1; end
        words_left--;
        burst_on = (words_left > 0);
      end else if (words_left == 0 && dma_req) begin
        words_left = 8;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(dma_req == 0 && pix_valid == 0, "R1 reset outputs", {dma_req, pix_valid}, 0);
    chk(urun_sts == 0 && irq == 0, "R1 reset flag", {urun_sts, irq}, 0);
    chk(wr_ready == 1, "R1 reset ready", wr_ready, 1);

    // Directed packing order at 16 bits per pixel.
    bpp_sel = 3'd4; enable = 1;
    @(negedge clk); @(negedge clk); #1;
    chk(dma_req == 1, "R2 request after enable", dma_req, 1);
    @(negedge clk); wr_valid = 1; wr_data = 32'h1111_2222;
    @(negedge clk); wr_data = 32'h3333_4444;
    @(negedge clk); wr_valid = 0; #1;
    chk(dma_req == 0, "R2 request dropped", dma_req, 0);
    chk(pix_valid == 1 && pix_data == 16'h2222, "R3 low word first", pix_data, 16'h2222);
    pix_ready = 1;
    @(negedge clk); #1; chk(pix_data == 16'h1111, "R3 pixel 1", pix_data, 16'h1111);
    @(negedge clk); #1; chk(pix_data == 16'h4444, "R3 second word high", pix_data, 16'h4444);
    @(negedge clk); #1; chk(pix_data == 16'h3333, "R3 pixel 3", pix_data, 16'h3333);
    @(negedge clk); #1; chk(pix_valid == 0, "R6 pop after last pixel", pix_valid, 0);
    chk(dma_req == 0, "R2 no request mid burst", dma_req, 0);

    // Underrun flag directed cases (valid low, ready high above).
    @(negedge clk); #1;
    chk(urun_sts == 1, "R7 underrun set", urun_sts, 1);
    chk(irq == 1, "R9 irq unmasked", irq, 1);
    pix_ready = 0; urun_mask = 1; #1;
    chk(irq == 0, "R9 irq masked", irq, 0);
    urun_mask = 0;
    repeat (3) @(negedge clk); #1;
    chk(urun_sts == 1, "R7 sticky", urun_sts, 1);
    urun_clr = 1; pix_ready = 1;
    @(negedge clk); #1;
    chk(urun_sts == 1, "R8 set beats clear", urun_sts, 1);
    pix_ready = 0;
    @(negedge clk); urun_clr = 0; #1;
    chk(urun_sts == 0, "R8 cleared", urun_sts, 0);
    chk(irq == 0, "R9 irq follows flag", irq, 0);

    // Fill with consumer stalled: queue full, no further request.
    restart(3'd3);
    run_random(120, 0, 80);
    chk(exp_q.size() == 8, "R3 model full", exp_q.size(), 8);
    chk(wr_ready == 0, "R3 full not ready", wr_ready, 0);
    chk(dma_req == 0, "R4 no request when full", dma_req, 0);
    run_random(1500, 70, 70);

    for (int s = 0; s < 6; s++) begin
      logic [2:0] sel = (s == 5) ? 3'd6 : 3'(s);
      restart(sel);
      run_random(2500, (s % 2) ? 90 : 50, (s % 2) ? 40 : 95);
    end

    // Flush keeps the flag.
    @(negedge clk); pix_ready = 1; @(negedge clk); pix_ready = 0;
    restart(3'd2); #1;
    chk(urun_sts == 1, "R10 flag kept over flush", urun_sts, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule